// File: doc/BRIEF.md
# Page-Mode Asynchronous Flash Read Sequencer

This block reads bursts of 16-bit words from an asynchronous NOR-style flash that supports page mode. A requester asks for a burst by giving a start word address and a word count. The block then drives chip select, output enable, an address-valid strobe, the word address and both byte enables toward the memory. It counts wait cycles on its single clock and captures each data word at the end of that word's wait window. Each captured word goes back to the requester with a one-cycle valid strobe.

Two static wait settings control the timing. A longer wait applies to the first word taken from any page. A shorter wait applies to each later word in the same page. When the incrementing address enters a new page, the longer wait applies again. The page size is also a static setting and can be 4, 8 or 16 words. While a burst runs, the block raises busy and ignores any new request.

Top module: `pgflash_rd`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_cs_n, mem_oe_n and mem_adv_n are 1, mem_be_n is 2'b11, busy is 0 and rsp_valid is 0.
- R2: A request (req_valid=1, req_len nonzero, block idle) is accepted at a clock edge. From the next cycle until the final word is captured, mem_cs_n=0, mem_oe_n=0, mem_be_n=2'b00 and busy=1.
- R3: The first word of a burst, and the first word of every new page, stays on the bus for cfg_first_wait+2 cycles before it is captured.
- R4: Each later word within the same page stays on the bus for cfg_page_wait+1 cycles.
- R5: cfg_page selects the page size: 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words. A word address whose low 2, 3 or 4 bits (for 4, 8 or 16 words) are all zero starts a new page.
- R6: mem_adv_n is 0 for exactly the first cycle of each page-first word, including the first word of the burst even when it is not page-aligned. It is 1 in all other cycles.
- R7: mem_addr holds the word address for the whole access. Successive words increase the address by one, modulo 2^24.
- R8: mem_data_in is sampled in the last cycle of a word's access. In the next cycle rsp_valid=1 and rsp_data carries the sampled word.
- R9: In the cycle that carries the final word's rsp_valid, mem_cs_n and mem_oe_n are already 1 and busy is 0. A request presented in that cycle is accepted.
- R10: A request made while busy=1, or one with req_len=0, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request strobe |
| req_addr | input | 24 | Start word address |
| req_len | input | 8 | Number of words in the burst |
| cfg_page | input | 2 | Page size select |
| cfg_first_wait | input | 4 | Wait field for a page-first word |
| cfg_page_wait | input | 4 | Wait field for in-page words |
| busy | output | 1 | Burst in progress |
| rsp_valid | output | 1 | Captured word valid (one cycle) |
| rsp_data | output | 16 | Captured word |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | 24 | Memory word address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_data_in | input | 16 | Memory read data |

## Verification
Bursts are run in several kinds of pattern, and each kind separates a different fault:
- Aligned bursts that stay inside one page separate the first-access wait from the in-page wait.
- Unaligned bursts that cross one or two boundaries, at each page size, show whether the page mask and the restart of the long wait are right.
- The extreme wait settings (0/0 and 15/15), a burst that wraps past the top address and a single-word burst cover the edges of the counters.
- Zero-length requests, requests held during a burst and a request made in the final response cycle check that requests are gated correctly.

// File: rtl/pgflash_pkg.sv
`timescale 1ns/1ps
package pgflash_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 4;
    localparam int LEN_W  = 8;
    localparam int PIDX_W = 4;

    typedef enum logic [1:0] {
        PG_4   = 2'd0,
        PG_8   = 2'd1,
        PG_16  = 2'd2,
        PG_16X = 2'd3
    } page_sel_e;

    typedef struct packed {
        logic active;
        logic adv_n;
    } seq_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    // low-address mask that must be all zero at a page start
    function automatic logic [PIDX_W-1:0] page_mask(page_sel_e sel);
        case (sel)
            PG_4:    return 4'h3;
            PG_8:    return 4'h7;
            default: return 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/pgflash_wait.sv
`timescale 1ns/1ps
module pgflash_wait #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              first,
    input  logic [WAIT_W-1:0] fw,
    input  logic [WAIT_W-1:0] pw,
    output logic              done
);
    localparam int CNT_W = WAIT_W + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= first ? (CNT_W'(fw) + CNT_W'(1)) : CNT_W'(pw);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pgflash_addr.sv
`timescale 1ns/1ps
module pgflash_addr
    import pgflash_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              step,
    input  page_sel_e         page_sel,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              next_first
);
    logic [LEN_W-1:0]  left;
    logic [ADDR_W-1:0] nxt;

    assign nxt = addr + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
        end else if (start) begin
            addr <= start_addr;
            left <= start_len;
        end else if (step) begin
            addr <= nxt;
            left <= left - LEN_W'(1);
        end
    end

    assign last       = (left == LEN_W'(1));
    assign next_first = ((nxt[PIDX_W-1:0] & page_mask(page_sel)) == '0);
endmodule

// File: rtl/pgflash_rd.sv
`timescale 1ns/1ps
module pgflash_rd
    import pgflash_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int WW = WAIT_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [1:0]    cfg_page,
    input  logic [WW-1:0] cfg_first_wait,
    input  logic [WW-1:0] cfg_page_wait,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_cs_n,
    output logic          mem_adv_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic [DW/8-1:0] mem_be_n,
    input  logic [DW-1:0] mem_data_in
);
    localparam int BE_W = DW / 8;

    seq_state_t st;
    rsp_t       rsp;
    page_sel_e  psel;
    logic       accept, word_end, more, wait_done, last_word, next_first, load_first;

    assign psel       = page_sel_e'(cfg_page);
    assign accept     = req_valid && !st.active && (req_len != '0);
    assign word_end   = st.active && wait_done;
    assign more       = word_end && !last_word;
    assign load_first = accept || next_first;

    pgflash_wait #(.WAIT_W(WW)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .load  (accept || more),
        .first (load_first),
        .fw    (cfg_first_wait),
        .pw    (cfg_page_wait),
        .done  (wait_done)
    );

    pgflash_addr #(.ADDR_W(AW), .LEN_W(LW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_addr (req_addr),
        .start_len  (req_len),
        .step       (word_end),
        .page_sel   (psel),
        .addr       (mem_addr),
        .last       (last_word),
        .next_first (next_first)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.active <= 1'b0;
            st.adv_n  <= 1'b1;
            rsp.valid <= 1'b0;
            rsp.data  <= '0;
        end else begin
            if (accept)
                st.active <= 1'b1;
            else if (word_end && last_word)
                st.active <= 1'b0;

            if (accept)
                st.adv_n <= 1'b0;
            else if (more)
                st.adv_n <= !next_first;
            else
                st.adv_n <= 1'b1;

            rsp.valid <= word_end;
            if (word_end)
                rsp.data <= mem_data_in;
        end
    end

    assign busy      = st.active;
    assign mem_cs_n  = !st.active;
    assign mem_oe_n  = !st.active;
    assign mem_adv_n = st.adv_n;
    assign rsp_valid = rsp.valid;
    assign rsp_data  = rsp.data;

    for (genvar b = 0; b < BE_W; b++) begin : g_be
        assign mem_be_n[b] = !st.active;
    end
endmodule

// File: rtl/pgflash_rd_chk.sv
`timescale 1ns/1ps
module pgflash_rd_chk #(
    parameter int AW = 24,
    parameter int BE_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            rsp_valid,
    input logic            mem_cs_n,
    input logic            mem_oe_n,
    input logic            mem_adv_n,
    input logic [AW-1:0]   mem_addr,
    input logic [BE_W-1:0] mem_be_n
);
    AST_CS_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n == mem_oe_n); // R2
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        busy == !mem_cs_n); // R2
    AST_BE_FULL: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> (mem_be_n == '0)); // R2
    AST_ADV_INSIDE: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> !mem_cs_n); // R6
    AST_ADV_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !mem_adv_n); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n) && !rsp_valid) |-> $stable(mem_addr)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && rsp_valid) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R7
    AST_END_RSP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid); // R9
endmodule

bind pgflash_rd pgflash_rd_chk #(.AW(AW), .BE_W(DW/8)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_adv_n (mem_adv_n),
    .mem_addr  (mem_addr),
    .mem_be_n  (mem_be_n)
);

// File: tb/pgflash_rd_test.sv
`timescale 1ns/1ps
module pgflash_rd_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [1:0]  cfg_page = '0;
    logic [3:0]  cfg_first_wait = '0;
    logic [3:0]  cfg_page_wait = '0;
    logic        busy, rsp_valid, mem_cs_n, mem_adv_n, mem_oe_n;
    logic [15:0] rsp_data, mem_data_in;
    logic [23:0] mem_addr;
    logic [1:0]  mem_be_n;

    always #10 clk = ~clk;

    pgflash_rd uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .cfg_page(cfg_page), .cfg_first_wait(cfg_first_wait),
        .cfg_page_wait(cfg_page_wait), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
        .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_data_in(mem_data_in)
    );

    // memory model: data is a fixed function of the address
    assign mem_data_in = mem_addr[15:0] ^ {mem_addr[23:16], 8'h5A};

    function automatic int mem_word(int a);
        int m = a & 24'hFFFFFF;
        return (m & 16'hFFFF) ^ ((((m >> 16) & 8'hFF) << 8) | 8'h5A);
    endfunction

    typedef struct {
        bit cs_n; bit adv_n; bit busy; bit rv; bit chk_addr;
        int addr; int data;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // expected per-cycle trace of one accepted burst
    task automatic push_burst(int a0, int len, int pg, int fw, int pw);
        int words = (pg >= 2) ? 16 : (4 << pg);
        int prev = 0;
        exp_t e;
        for (int i = 0; i < len; i++) begin
            int a = (a0 + i) & 24'hFFFFFF;
            bit pf = (i == 0) || ((a % words) == 0);
            int d = pf ? fw + 2 : pw + 1;
            for (int c = 0; c < d; c++) begin
                e.cs_n = 0; e.adv_n = !(c == 0 && pf); e.busy = 1;
                e.rv = (c == 0 && i > 0); e.chk_addr = 1; e.addr = a;
                e.data = mem_word(prev);
                q.push_back(e);
            end
            prev = a;
        end
        e.cs_n = 1; e.adv_n = 1; e.busy = 0; e.rv = 1; e.chk_addr = 0;
        e.addr = 0; e.data = mem_word(prev);
        q.push_back(e);
    endtask

    task automatic compare();
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.cs_n = 1; e.adv_n = 1; e.busy = 0; e.rv = 0; e.chk_addr = 0;
            e.addr = 0; e.data = 0;
        end
        chk(mem_cs_n == e.cs_n, "R2 R1", "cs_n", int'(mem_cs_n), int'(e.cs_n));
        chk(mem_oe_n == e.cs_n, "R2 R1", "oe_n", int'(mem_oe_n), int'(e.cs_n));
        chk(mem_be_n == (e.cs_n ? 2'b11 : 2'b00), "R2", "be_n", int'(mem_be_n),
            e.cs_n ? 3 : 0);
        chk(busy == e.busy, "R9 R10", "busy", int'(busy), int'(e.busy));
        chk(mem_adv_n == e.adv_n, "R6 R5", "adv_n", int'(mem_adv_n), int'(e.adv_n));
        if (e.chk_addr)
            chk(int'(mem_addr) == e.addr, "R7", "addr", int'(mem_addr), e.addr);
        chk(rsp_valid == e.rv, "R3 R4 R8", "rsp_valid", int'(rsp_valid), int'(e.rv));
        if (e.rv)
            chk(int'(rsp_data) == e.data, "R8", "rsp_data", int'(rsp_data), e.data);
    endtask

    task automatic step();
        if (!rst && req_valid && req_len != 0 && q.size() == 0)
            push_burst(int'(req_addr), int'(req_len), int'(cfg_page),
                       int'(cfg_first_wait), int'(cfg_page_wait));
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic drain();
        while (q.size() > 0) step();
    endtask

    task automatic issue(int a, int len, int pg, int fw, int pw);
        cfg_page = 2'(pg); cfg_first_wait = 4'(fw); cfg_page_wait = 4'(pw);
        req_addr = 24'(a); req_len = 8'(len); req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        drain();
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=busy expected=idle");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (3) step();
        rst = 1'b0;
        step();
        // R3 R4: aligned burst inside one 8-word page
        issue(24'h000010, 8, 1, 3, 1);
        // R5 R6: unaligned 4-word pages, two boundaries crossed
        issue(24'h000102, 7, 0, 2, 0);
        // R5: 16-word page, minimum waits
        issue(24'h0000F0, 18, 2, 0, 0);
        // R3 R4: maximum waits, page select 3
        issue(24'h12345D, 5, 3, 15, 15);
        // R7: address wrap at the top of the space
        issue(24'hFFFFFE, 4, 0, 1, 2);
        // R8: single-word burst
        issue(24'h00ABCD, 1, 1, 4, 0);
        // R10: zero-length request has no effect
        req_addr = 24'h000300; req_len = 8'd0; req_valid = 1'b1;
        repeat (3) step();
        req_valid = 1'b0;
        step();
        // R10: requests held during a burst are ignored
        cfg_page = 2'd1; cfg_first_wait = 4'd6; cfg_page_wait = 4'd2;
        req_addr = 24'h000040; req_len = 8'd3; req_valid = 1'b1;
        step();
        req_addr = 24'h000777; req_len = 8'd9;
        repeat (4) step();
        req_valid = 1'b0;
        drain();
        step();
        // R9: new request in the final response cycle is accepted
        cfg_page = 2'd0; cfg_first_wait = 4'd1; cfg_page_wait = 4'd0;
        req_addr = 24'h000201; req_len = 8'd4; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        drain();
        req_addr = 24'h000500; req_len = 8'd2; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        drain();
        repeat (2) step();
        summary();
        $finish;
    end
endmodule